// File: doc/BRIEF.md
# Packed Channel Event Interrupt Controller

This block gathers completion events from a bank of DMA channels and turns them into a single interrupt line. Each channel raises three kinds of one-cycle event pulse: half of a transfer done, one descriptor finished, and the whole descriptor queue finished. Every pulse is latched into a sticky status bit. Each status bit is gated by its own enable bit, and any gated bit drives the interrupt output high.

Software reaches the block through a plain 32-bit register port: an address, write data, a write strobe and combinational read data. Each channel owns a 4-bit field, and eight fields are packed into each 32-bit word, so the channels are spread over two enable words and two status words. Software acknowledges events by writing the status value it just read back to the status word. A summary word shows, one bit per channel, which channels hold any latched event.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every enable and status bit is 0, the interrupt output is low, and all mapped registers read 0.
- R2: Enable words sit at byte address 0x00 (channels 0-7) and 0x04 (channels 8-15). A write stores the data, and a read returns it with bit 3 of every nibble forced to 0, which is the mask 0x77777777.
- R3: A pulse on channel n sets bit 4*(n mod 8)+k of the status word at 0x10 (channels 0-7) or 0x14 (channels 8-15). Here k is 0 for half-transfer, 1 for descriptor done and 2 for queue done. The bit reads as set in the cycle after the pulse, whatever the enable bit holds.
- R4: A write to a status word clears each bit where the data holds 1 and leaves each bit where the data holds 0. A write never sets a status bit.
- R5: If an event and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R6: The interrupt output is high exactly when some status bit and its matching enable bit are both 1. It follows status and enable changes with no extra register stage.
- R7: The summary word at 0x30 has bit n set when channel n holds any status bit, enabled or not. Bits 31:16 read 0.
- R8: Addresses other than 0x00, 0x04, 0x10, 0x14 and 0x30 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_half | input | 16 | Half-transfer event pulse, one bit per channel |
| evt_pkg | input | 16 | Descriptor-done event pulse, one bit per channel |
| evt_queue | input | 16 | Queue-done event pulse, one bit per channel |
| reg_addr | input | 8 | Byte address for register reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
Event pulses and register writes take effect at the first rising edge that sees them. Status, enable, summary and interrupt values are therefore due one cycle after the stimulus. Read data is combinational from the address, so it is valid within the same cycle. The bench drives every input on the falling edge and holds it through one rising edge. It then checks results on the next falling edge, sampling read data a fraction of a nanosecond after it sets the address. For the race case, a pulse and a clearing write share the same cycle, and the bit is read back on the following falling edge.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants for the packed channel event interrupt controller.
// Assumes byte addressing with 32-bit registers and four bits per channel.
package dma_irq_pkg;
    localparam int FLD_W      = 4;                 // bits per channel field
    localparam int EVT_W      = 3;                 // live event bits per field
    localparam int WORD_W     = 32;
    localparam int CH_PER_REG = WORD_W / FLD_W;    // channels per register word
    localparam int ADDR_W     = 8;

    localparam logic [ADDR_W-1:0] EN_BASE  = 8'h00;
    localparam logic [ADDR_W-1:0] STS_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] SUM_ADDR = 8'h30;

    // Event index within a channel field
    typedef enum logic [1:0] {
        EVT_HALF  = 2'd0,
        EVT_PKG   = 2'd1,
        EVT_QUEUE = 2'd2
    } evt_kind_e;

    // Field mask with the reserved top bit cleared
    localparam logic [FLD_W-1:0] FLD_MASK = {1'b0, {EVT_W{1'b1}}};
endpackage

// File: rtl/dma_irq_bank.sv
// Module: one register word worth of channels (enable and sticky status).
// Assumes event inputs are single-cycle pulses, and that each write strobe
// is already decoded for this word. Events win over clears in the same cycle.
module dma_irq_bank
    import dma_irq_pkg::*;
#(
    parameter int CH = CH_PER_REG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH-1:0]     evt_half,
    input  logic [CH-1:0]     evt_pkg,
    input  logic [CH-1:0]     evt_queue,
    input  logic              en_wr,
    input  logic              sts_wr,
    input  logic [CH*FLD_W-1:0] wdata,
    output logic [CH*FLD_W-1:0] en_q,
    output logic [CH*FLD_W-1:0] sts_q,
    output logic [CH-1:0]     ch_any,
    output logic              pend
);
    localparam int W = CH * FLD_W;

    logic [W-1:0] evt_vec;
    logic [W-1:0] keep_mask;
    logic [W-1:0] clr_vec;

    genvar c;
    generate
        for (c = 0; c < CH; c++) begin : g_ch
            // Pack this channel's three pulses into its field
            assign evt_vec[c*FLD_W +: FLD_W] = {1'b0, evt_queue[c], evt_pkg[c], evt_half[c]};
            assign keep_mask[c*FLD_W +: FLD_W] = FLD_MASK;
            // Per-channel flag: any latched event
            assign ch_any[c] = |sts_q[c*FLD_W +: FLD_W];
        end
    endgenerate

    // Bits cleared by a status write this cycle
    assign clr_vec = sts_wr ? wdata : '0;

    // Enable word: reset to zero, load masked data on write
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_wr)
            en_q <= wdata & keep_mask;
    end

    // Status word: clear on ones, then OR in new events so they win
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= '0;
        else
            sts_q <= (sts_q & ~clr_vec) | evt_vec;
    end

    // Gated pending flag for this word
    assign pend = |(sts_q & en_q);
endmodule

// File: rtl/dma_irq_rdmux.sv
// Module: combinational read multiplexer for the enable, status and summary
// words. Assumes the inputs are flat vectors with word r at bits [32r +: 32].
// Unmapped addresses return zero.
module dma_irq_rdmux
    import dma_irq_pkg::*;
#(
    parameter int NUM_REG = 2,
    parameter int NUM_CH  = NUM_REG * CH_PER_REG
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_REG*WORD_W-1:0] en_all,
    input  logic [NUM_REG*WORD_W-1:0] sts_all,
    input  logic [NUM_CH-1:0]         ch_any,
    output logic [WORD_W-1:0]         rdata
);
    // Select the addressed word, or the summary word, or zero
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REG; r++) begin
            if (addr == EN_BASE + ADDR_W'(4 * r))
                rdata = en_all[r*WORD_W +: WORD_W];
            if (addr == STS_BASE + ADDR_W'(4 * r))
                rdata = sts_all[r*WORD_W +: WORD_W];
        end
        if (addr == SUM_ADDR)
            rdata = WORD_W'(ch_any);
    end
endmodule

// File: rtl/dma_irq_ctrl.sv
// Module: top level of the packed channel event interrupt controller.
// Decodes register writes, instantiates one bank per packed word, and ORs the
// banks' gated pending flags into irq. Assumes one register access per cycle.
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     evt_half,
    input  logic [NUM_CH-1:0]     evt_pkg,
    input  logic [NUM_CH-1:0]     evt_queue,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    input  logic                  reg_wr,
    output logic [WORD_W-1:0]     reg_rdata,
    output logic                  irq
);
    localparam int NUM_REG = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG;

    logic [NUM_REG*WORD_W-1:0] en_all;
    logic [NUM_REG*WORD_W-1:0] sts_all;
    logic [NUM_CH-1:0]         ch_any;
    logic [NUM_REG-1:0]        pend;

    genvar r;
    generate
        for (r = 0; r < NUM_REG; r++) begin : g_bank
            logic en_wr, sts_wr;
            // Write decode for this word
            assign en_wr  = reg_wr && (reg_addr == EN_BASE  + ADDR_W'(4 * r));
            assign sts_wr = reg_wr && (reg_addr == STS_BASE + ADDR_W'(4 * r));

            dma_irq_bank #(.CH(CH_PER_REG)) i_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt_half (evt_half [r*CH_PER_REG +: CH_PER_REG]),
                .evt_pkg  (evt_pkg  [r*CH_PER_REG +: CH_PER_REG]),
                .evt_queue(evt_queue[r*CH_PER_REG +: CH_PER_REG]),
                .en_wr    (en_wr),
                .sts_wr   (sts_wr),
                .wdata    (reg_wdata),
                .en_q     (en_all [r*WORD_W +: WORD_W]),
                .sts_q    (sts_all[r*WORD_W +: WORD_W]),
                .ch_any   (ch_any [r*CH_PER_REG +: CH_PER_REG]),
                .pend     (pend[r])
            );
        end
    endgenerate

    dma_irq_rdmux #(.NUM_REG(NUM_REG), .NUM_CH(NUM_CH)) i_rdmux (
        .addr   (reg_addr),
        .en_all (en_all),
        .sts_all(sts_all),
        .ch_any (ch_any),
        .rdata  (reg_rdata)
    );

    // Combined interrupt from all words
    assign irq = |pend;
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
// Module: assertion checker bound to dma_irq_ctrl. It watches the event
// pulses, the register port and the internal packed state.
module dma_irq_ctrl_chk
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        evt_half,
    input logic [NUM_CH-1:0]        evt_pkg,
    input logic [NUM_CH-1:0]        evt_queue,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [WORD_W-1:0]        reg_wdata,
    input logic                     reg_wr,
    input logic [WORD_W-1:0]        reg_rdata,
    input logic                     irq,
    input logic [((NUM_CH+CH_PER_REG-1)/CH_PER_REG)*WORD_W-1:0] sts_all
);
    // Enable and status words never show reserved bits (R2)
    assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h00 || reg_addr == 8'h04 || reg_addr == 8'h10 || reg_addr == 8'h14)
        |-> ((reg_rdata & 32'h8888_8888) == 32'h0));

    // Without events or writes the interrupt cannot change (R6)
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !(|evt_half) && !(|evt_pkg) && !(|evt_queue)) |=> $stable(irq));

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chk
            localparam int B = (c / CH_PER_REG) * WORD_W + (c % CH_PER_REG) * FLD_W;
            localparam logic [ADDR_W-1:0] SA = STS_BASE + ADDR_W'(4 * (c / CH_PER_REG));

            // Each pulse latches its status bit (R3, R5)
            assert_half_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
                evt_half[c] |=> sts_all[B]);
            assert_pkg_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
                evt_pkg[c] |=> sts_all[B+1]);
            assert_queue_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
                evt_queue[c] |=> sts_all[B+2]);

            // A one written to the half bit clears it when no event races (R4)
            assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr && reg_addr == SA && reg_wdata[(c % CH_PER_REG) * FLD_W] && !evt_half[c])
                |=> !sts_all[B]);
        end
    endgenerate
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_half(evt_half), .evt_pkg(evt_pkg),
    .evt_queue(evt_queue), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq), .sts_all(sts_all)
);

// File: tb/test_dma_irq_ctrl.sv
`timescale 1ns/1ps
// Directed bench for dma_irq_ctrl: one task per scenario.
module test_dma_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_half = '0, evt_pkg = '0, evt_queue = '0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    dma_irq_ctrl i_dma_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_half(evt_half), .evt_pkg(evt_pkg),
        .evt_queue(evt_queue), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [15:0] h, input logic [15:0] p, input logic [15:0] q);
        @(negedge clk);
        evt_half = h; evt_pkg = p; evt_queue = q;
        @(negedge clk);
        evt_half = '0; evt_pkg = '0; evt_queue = '0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(8'h00, d); check("R1", "en0 after reset", d, 0);
        rd(8'h04, d); check("R1", "en1 after reset", d, 0);
        rd(8'h10, d); check("R1", "sts0 after reset", d, 0);
        rd(8'h14, d); check("R1", "sts1 after reset", d, 0);
        rd(8'h30, d); check("R1", "summary after reset", d, 0);
        check("R1", "irq after reset", {31'b0, irq}, 0);
    endtask

    task automatic t_enable_rw();
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R2", "en0 masked", d, 32'h7777_7777);
        wr(8'h04, 32'h1234_5678);
        rd(8'h04, d); check("R2", "en1 masked", d, 32'h1234_5670);
        wr(8'h00, 0); wr(8'h04, 0);
        rd(8'h00, d); check("R2", "en0 cleared", d, 0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        pulse(16'h0, 16'h0, 16'h0800);               // queue on ch 11
        rd(8'h14, d); check("R3", "ch11 queue bit 14", d, 32'h0000_4000);
        check("R6", "irq low while disabled", {31'b0, irq}, 0);
        pulse(16'h0004, 16'h0, 16'h0);               // half on ch 2
        rd(8'h10, d); check("R3", "ch2 half bit 8", d, 32'h0000_0100);
        pulse(16'h0, 16'h0001, 16'h0);               // pkg on ch 0
        rd(8'h10, d); check("R3", "ch0 pkg bit 1 added", d, 32'h0000_0102);
        rd(8'h30, d); check("R7", "summary ch 0,2,11", d, 32'h0000_0805);
    endtask

    task automatic t_irq_mask();
        wr(8'h04, 32'h0000_4000);
        check("R6", "irq with ch11 queue enabled", {31'b0, irq}, 1);
        wr(8'h04, 32'h0000_2000);
        check("R6", "irq with other bit enabled", {31'b0, irq}, 0);
        wr(8'h04, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(8'h10, 32'h0000_0100);
        rd(8'h10, d); check("R4", "clear ch2 half only", d, 32'h0000_0002);
        wr(8'h10, 32'h0);
        rd(8'h10, d); check("R4", "zero write keeps bits", d, 32'h0000_0002);
        wr(8'h10, 32'h0000_0002);
        rd(8'h10, d); check("R4", "clear ch0 pkg", d, 0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d); check("R4", "all-ones clears sts1", d, 0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d); check("R4", "write never sets", d, 0);
        rd(8'h30, d); check("R7", "summary empty", d, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        pulse(16'h0, 16'h0200, 16'h0);               // pkg on ch 9 -> bit 5
        @(negedge clk);
        reg_addr = 8'h14; reg_wdata = 32'h0000_0020; reg_wr = 1'b1;
        evt_pkg = 16'h0200;
        @(negedge clk);
        reg_wr = 1'b0; evt_pkg = '0;
        rd(8'h14, d); check("R5", "event beats clear", d, 32'h0000_0020);
        wr(8'h14, 32'h0000_0020);
        rd(8'h14, d); check("R5", "cleared afterwards", d, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h00, 32'h0000_0011);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R8", "read 0x08", d, 0);
        rd(8'h20, d); check("R8", "read 0x20", d, 0);
        rd(8'h00, d); check("R8", "en0 untouched", d, 32'h0000_0011);
        rd(8'h04, d); check("R8", "en1 untouched", d, 0);
    endtask

    task automatic t_reset_again();
        logic [31:0] d;
        pulse(16'h0001, 16'h0, 16'h0);
        check("R6", "irq before reset", {31'b0, irq}, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(8'h10, d); check("R1", "sts0 after reset", d, 0);
        rd(8'h00, d); check("R1", "en0 after reset", d, 0);
        check("R1", "irq after reset", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_enable_rw();
        t_latch();
        t_irq_mask();
        t_w1c();
        t_race();
        t_unmapped();
        t_reset_again();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule